// File: doc/BRIEF.md
# Gated Serial Word Exchange Sequencer

This block carries out one request/response transaction with a remote panel over a pair of clocked serial links. A rising edge on the start input begins a receive phase. During that phase the block drives a gated bit clock toward the panel, and it shifts in 32 data bits, most significant first. When the receive phase is complete, the captured word appears in parallel. Two 3-bit designator fields inside it are decoded into one-hot groups of five lines. The block then raises an end-of-receive strobe for a fixed number of system cycles. The reply word is taken from a parallel input port at the trailing edge of that strobe. A second gated clock then carries its 16 bits back to the panel, most significant first.

The bit rate comes from a single-cycle enable, `bit_tick`, on the system clock. Each tick moves the active gated clock by one half period, so a bit period is two ticks. Each direction has its own set/clear arming latch. The receive latch is set by the start edge and cleared when the end-of-receive strobe begins. The transmit latch is set at that same moment and cleared when the last bit has gone out. The captured word is flagged by `cap_valid_o`. There is no ready input, because the exchange runs at the panel's bit rate and cannot be stalled. The flag and the word hold until the next exchange starts, so a consumer can read them at any point in between. The mapping from captured bits to the reply is done outside the block and arrives on `resp_i`.

Top module: `serial_xchg_seq`

## Requirements
- R1: After reset, `in_clk_o`, `out_clk_o`, `sdo_o`, `eoc_o`, `cap_valid_o` and `done_o` are all low.
- R2: A rising edge of `start_i` while idle starts a receive phase. In that phase `in_clk_o` toggles once per `bit_tick` and shows exactly 32 rising edges.
- R3: `sdi_i` is sampled on the system clock edge at which `in_clk_o` goes high, first bit into bit 31. After the receive phase, `cap_word_o` holds the 32 bits and `cap_valid_o` is high. Both hold until the next exchange starts.
- R4: `eoc_o` goes high after the falling edge that follows the 32nd rising edge of `in_clk_o`. It stays high for exactly EOC_LEN system cycles (default 4), and `in_clk_o` is low throughout.
- R5: The platform code is `cap_word_o[31:29]` and the relay code is `cap_word_o[28:26]`, with bit weights 4, 2, 1 from high to low. A code value v from 1 to 5 drives bit v-1 of its 5-bit group. Codes 0, 6 and 7 drive the group to zero and set the matching flag: `code_bad_o[0]` for platform, `code_bad_o[1]` for relay.
- R6: The reply word is the value of `resp_i` in the last cycle of the `eoc_o` strobe. Changes of `resp_i` before or after that cycle have no effect on the transmitted bits.
- R7: After the strobe, `out_clk_o` shows exactly 16 rising edges. `sdo_o` carries reply bit 15 first and moves to the next lower bit on each falling edge of `out_clk_o`.
- R8: `done_o` is high for exactly one cycle per exchange, after the 16th output bit.
- R9: Rising edges of `start_i` during an active exchange are ignored. The running exchange completes unchanged, and no further exchange follows it.
- R10: `in_clk_o` and `out_clk_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Half-bit-period enable pulse |
| start_i | input | 1 | Exchange start; rising edge is the trigger |
| sdi_i | input | 1 | Serial data from the panel |
| in_clk_o | output | 1 | Gated receive bit clock |
| out_clk_o | output | 1 | Gated transmit bit clock |
| sdo_o | output | 1 | Serial data to the panel |
| cap_word_o | output | 32 | Captured word |
| cap_valid_o | output | 1 | Captured word is complete |
| plat_sel_o | output | 5 | One-hot platform designator |
| relay_sel_o | output | 5 | One-hot relay designator |
| code_bad_o | output | 2 | Out-of-range designator flags (bit 0 platform, bit 1 relay) |
| eoc_o | output | 1 | End-of-receive strobe |
| resp_i | input | 16 | Reply word to transmit |
| done_o | output | 1 | Exchange finished pulse |

## Verification
A wrong bit counter shows at the ports within one exchange. The number of gated clock edges is off, and the captured word or the reply is shifted by a position as soon as the strobe begins or `done_o` rises. A sequencer that leaves a phase early or late changes the strobe width or the moment the reply is latched. Driving `resp_i` with distinct values before, during and after the strobe exposes this in the returned bits. A stuck arming latch shows up as clock edges in the idle window after `done_o`, or as a second exchange after an ignored start edge.

// File: rtl/serial_xchg_pkg.sv
package serial_xchg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_EOC  = 2'd2,
    ST_SEND = 2'd3
  } xchg_state_e;
endpackage

// File: rtl/bitclk_gate.sv
module bitclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic clk_o,
  output logic rise_o,
  output logic fall_o
);
  logic clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       clk_q <= 1'b0;
    else if (!en_i)   clk_q <= 1'b0;
    else if (tick_i)  clk_q <= ~clk_q;
  end

  assign rise_o = en_i & tick_i & ~clk_q;
  assign fall_o = en_i & tick_i &  clk_q;
  assign clk_o  = clk_q;

  // R2
  tick_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(clk_q));
endmodule

// File: rtl/cap_shift.sv
module cap_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], sdi_i};
  end
endmodule

// File: rtl/reply_shift.sv
module reply_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         sdo_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign sdo_o = sr_q[W-1];

  // R7
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sdo_o));
endmodule

// File: rtl/desig_decode.sv
module desig_decode #(
  parameter int FW = 3,
  parameter int GW = 5
) (
  input  logic [FW-1:0] code_i,
  output logic [GW-1:0] sel_o,
  output logic          bad_o
);
  always_comb begin
    sel_o = '0;
    for (int k = 0; k < GW; k++) begin
      if (int'(code_i) == k + 1) sel_o[k] = 1'b1;
    end
    bad_o = ~|sel_o;
  end

  // R5
  always_comb begin
    sel_onehot_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/serial_xchg_seq.sv
module serial_xchg_seq
  import serial_xchg_pkg::*;
#(
  parameter int IN_BITS   = 32,
  parameter int OUT_BITS  = 16,
  parameter int EOC_LEN   = 4,
  parameter int FIELD_W   = 3,
  parameter int GROUP_W   = 5,
  parameter int PLAT_LSB  = 29,
  parameter int RELAY_LSB = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                start_i,
  input  logic                sdi_i,
  output logic                in_clk_o,
  output logic                out_clk_o,
  output logic                sdo_o,
  output logic [IN_BITS-1:0]  cap_word_o,
  output logic                cap_valid_o,
  output logic [GROUP_W-1:0]  plat_sel_o,
  output logic [GROUP_W-1:0]  relay_sel_o,
  output logic [1:0]          code_bad_o,
  output logic                eoc_o,
  input  logic [OUT_BITS-1:0] resp_i,
  output logic                done_o
);
  localparam int ICW = $clog2(IN_BITS + 1);
  localparam int OCW = $clog2(OUT_BITS);
  localparam int ECW = (EOC_LEN > 1) ? $clog2(EOC_LEN) : 1;
  localparam logic [ICW-1:0] IN_FULL  = ICW'(IN_BITS);
  localparam logic [OCW-1:0] OUT_LAST = OCW'(OUT_BITS - 1);
  localparam logic [ECW-1:0] EOC_LAST = ECW'(EOC_LEN - 1);
  localparam int LSB_TAB [2] = '{PLAT_LSB, RELAY_LSB};

  xchg_state_e     state_q;
  logic [ICW-1:0]  in_cnt_q;
  logic [OCW-1:0]  out_cnt_q;
  logic [ECW-1:0]  eoc_cnt_q;
  logic            start_q, in_arm_q, out_arm_q;
  logic            in_rise, in_fall, out_rise, out_fall;
  logic            out_gate, start_edge, reply_load;
  logic [GROUP_W-1:0] grp_sel [2];

  assign start_edge = start_i & ~start_q;
  assign out_gate   = out_arm_q & (state_q == ST_SEND);
  assign reply_load = (state_q == ST_EOC) && (eoc_cnt_q == EOC_LAST);
  assign eoc_o      = (state_q == ST_EOC);

  bitclk_gate u_in_gate (
    .clk(clk), .rst_n(rst_n), .en_i(in_arm_q), .tick_i(bit_tick),
    .clk_o(in_clk_o), .rise_o(in_rise), .fall_o(in_fall));

  bitclk_gate u_out_gate (
    .clk(clk), .rst_n(rst_n), .en_i(out_gate), .tick_i(bit_tick),
    .clk_o(out_clk_o), .rise_o(out_rise), .fall_o(out_fall));

  cap_shift #(.W(IN_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift_i(in_rise), .sdi_i(sdi_i),
    .word_o(cap_word_o));

  reply_shift #(.W(OUT_BITS)) u_reply (
    .clk(clk), .rst_n(rst_n), .load_i(reply_load), .data_i(resp_i),
    .shift_i(out_fall), .sdo_o(sdo_o));

  for (genvar g = 0; g < 2; g++) begin : g_dec
    desig_decode #(.FW(FIELD_W), .GW(GROUP_W)) u_dec (
      .code_i(cap_word_o[LSB_TAB[g] +: FIELD_W]),
      .sel_o(grp_sel[g]),
      .bad_o(code_bad_o[g]));
  end
  assign plat_sel_o  = grp_sel[0];
  assign relay_sel_o = grp_sel[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      in_cnt_q    <= '0;
      out_cnt_q   <= '0;
      eoc_cnt_q   <= '0;
      start_q     <= 1'b0;
      in_arm_q    <= 1'b0;
      out_arm_q   <= 1'b0;
      cap_valid_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      start_q <= start_i;
      done_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_edge) begin
          state_q     <= ST_RECV;
          in_arm_q    <= 1'b1;
          in_cnt_q    <= '0;
          cap_valid_o <= 1'b0;
        end
        ST_RECV: begin
          if (in_rise) in_cnt_q <= in_cnt_q + 1'b1;
          if (in_fall && in_cnt_q == IN_FULL) begin
            state_q     <= ST_EOC;
            in_arm_q    <= 1'b0;
            out_arm_q   <= 1'b1;
            eoc_cnt_q   <= '0;
            cap_valid_o <= 1'b1;
          end
        end
        ST_EOC: begin
          eoc_cnt_q <= eoc_cnt_q + 1'b1;
          if (eoc_cnt_q == EOC_LAST) begin
            state_q   <= ST_SEND;
            out_cnt_q <= '0;
          end
        end
        ST_SEND: if (out_fall) begin
          out_cnt_q <= out_cnt_q + 1'b1;
          if (out_cnt_q == OUT_LAST) begin
            state_q   <= ST_IDLE;
            out_arm_q <= 1'b0;
            done_o    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  clk_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_clk_o && out_clk_o));

  // R4
  eoc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> !in_clk_o && !out_clk_o);

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |=> (!cap_valid_o || $stable(cap_word_o)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/tb_serial_xchg_seq.sv
module tb_serial_xchg_seq;
  localparam int CLK_P = 10;
  localparam int EOC_LEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        start_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        in_clk_o, out_clk_o, sdo_o, cap_valid_o, eoc_o, done_o;
  logic [31:0] cap_word_o;
  logic [4:0]  plat_sel_o, relay_sel_o;
  logic [1:0]  code_bad_o;
  logic [15:0] resp_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  int tick_div = 1;
  int tick_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_xchg_seq #(.EOC_LEN(EOC_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start_i(start_i),
    .sdi_i(sdi_i), .in_clk_o(in_clk_o), .out_clk_o(out_clk_o),
    .sdo_o(sdo_o), .cap_word_o(cap_word_o), .cap_valid_o(cap_valid_o),
    .plat_sel_o(plat_sel_o), .relay_sel_o(relay_sel_o),
    .code_bad_o(code_bad_o), .eoc_o(eoc_o), .resp_i(resp_i),
    .done_o(done_o));

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt = 0;
      bit_tick <= 1'b1;
    end else begin
      tick_cnt = tick_cnt + 1;
      bit_tick <= 1'b0;
    end
  end

  function automatic logic [4:0] exp_sel(input logic [2:0] code);
    logic [4:0] s = '0;
    if (code >= 3'd1 && code <= 3'd5) s[code - 3'd1] = 1'b1;
    return s;
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_x(input logic [31:0] w, input logic [15:0] ra,
                       input logic [15:0] rb, input int div, input bit inject);
    int in_r = 0, out_r = 0, eoc_w = 0, done_n = 0, post = 0, cyc = 0;
    logic pin = 1'b0, pout = 1'b0, peoc = 1'b0, both = 1'b0;
    logic inj1 = 1'b0, inj2 = 1'b0;
    logic [15:0] rx = '0;
    tick_div = div;
    resp_i = ra;
    sdi_i = w[31];
    @(negedge clk) start_i = 1'b1;
    while (post < 40 * div + 10 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (inject && in_r == 10 && !inj1) begin start_i = 1'b1; inj1 = 1'b1; end
      if (inject && out_r == 5 && !inj2) begin start_i = 1'b1; inj2 = 1'b1; end
      if (in_clk_o && !pin) begin
        in_r++;
        if (in_r < 32) sdi_i = w[31 - in_r];
      end
      if (out_clk_o && !pout) begin
        out_r++;
        rx = {rx[14:0], sdo_o};
      end
      if (in_clk_o && out_clk_o) both = 1'b1;
      if (eoc_o) begin
        eoc_w++;
        if (!peoc) resp_i = rb;
      end
      if (!eoc_o && peoc) resp_i = 16'($urandom);
      if (done_o) done_n++;
      if (done_n > 0) post++;
      pin = in_clk_o; pout = out_clk_o; peoc = eoc_o;
    end
    chk(cyc < 20000, "R8 exchange finished in time", 32'(cyc), 32'd20000);
    chk(in_r == 32, "R2 receive clock rising edges", 32'(in_r), 32'd32);
    chk(cap_word_o == w, "R3 captured word", cap_word_o, w);
    chk(cap_valid_o == 1'b1, "R3 capture valid held", 32'(cap_valid_o), 32'd1);
    chk(eoc_w == EOC_LEN, "R4 strobe width", 32'(eoc_w), 32'(EOC_LEN));
    chk(plat_sel_o == exp_sel(w[31:29]), "R5 platform group", 32'(plat_sel_o), 32'(exp_sel(w[31:29])));
    chk(relay_sel_o == exp_sel(w[28:26]), "R5 relay group", 32'(relay_sel_o), 32'(exp_sel(w[28:26])));
    chk(code_bad_o == {~|exp_sel(w[28:26]), ~|exp_sel(w[31:29])}, "R5 bad code flags",
        32'(code_bad_o), 32'({~|exp_sel(w[28:26]), ~|exp_sel(w[31:29])}));
    chk(rx == rb, "R6 reply latched at strobe end", 32'(rx), 32'(rb));
    chk(out_r == 16, "R7 transmit clock rising edges", 32'(out_r), 32'd16);
    chk(done_n == 1, "R8 done pulses", 32'(done_n), 32'd1);
    chk(!both, "R10 clocks overlap", 32'(both), 32'd0);
    if (inject)
      chk(in_r == 32 && out_r == 16 && done_n == 1, "R9 start during exchange ignored",
          32'(in_r + out_r), 32'd48);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({in_clk_o, out_clk_o, sdo_o, eoc_o, cap_valid_o, done_o} == 6'b0,
        "R1 idle outputs after reset",
        32'({in_clk_o, out_clk_o, sdo_o, eoc_o, cap_valid_o, done_o}), 32'd0);
    // directed: every designator code in both fields
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w = $urandom;
      w[31:29] = 3'(i);
      w[28:26] = 3'(7 - i);
      run_x(w, 16'($urandom), 16'($urandom), 1 + (i % 3), (i % 2) == 1);
    end
    // corner words
    run_x(32'hFFFF_FFFF, 16'h0000, 16'hFFFF, 1, 1'b0);
    run_x(32'h0000_0001, 16'hFFFF, 16'h8001, 2, 1'b1);
    // random
    for (int i = 0; i < 12; i++)
      run_x($urandom, 16'($urandom), 16'($urandom), 1 + int'($urandom % 3), ($urandom % 2) == 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule